// File: doc/BRIEF.md
# Parallel Flash Bus-Mode Controller

This block is the device-side control logic of a small parallel NOR-style flash. It watches four active-low pins (chip enable, output enable, write enable and a device reset that doubles as the deep power-down request). From them it works out whether the 16-bit data bus should be driven, which read view is presented (array words, identifier codes or the status byte), and when a command byte is taken. The storage behind it is a small register file. Erase and program run as a fixed-length busy countdown that updates the register file only when the countdown finishes.

A host selects the read view with one command write. It programs a word with a two-write sequence and erases a block with a single write. While an operation runs the host polls the ready output or the status byte. Dropping chip enable puts the bus in standby but does not stop a running operation. Pulling the device reset low stops the operation and returns the block to its power-up view. After the reset rises, a wake-up delay blocks the outputs and a longer recovery delay blocks command writes.

Top module: `flash_bus_ctrl`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1, `dev_rst_n`=1 and the wake-up delay has elapsed. `dq_out` is 0 whenever `dq_oe` is 0.
- R2: A command is taken from `dq_in[7:0]` on a clock where `we_n` is sampled 1 after being 0 on the previous clock while `ce_n` is 0. The read views are selected as follows: 0xFF gives array, 0x90 gives identifier, 0x70 gives status. In the identifier view, address bits [1:0] select the output: 0 returns the manufacturer code, 1 returns the device code, 2 returns the lock bit of the addressed block in bit 0, and 3 returns 0.
- R3: After system reset the array view is active, every word reads 0xFFFF, every block is locked and `ready` is 1.
- R4: Command 0x40 followed by a second write of data D to address A sets word A to (old AND D). The block number is the top BLK_W address bits.
- R5: Command 0x20 at any address in a block sets every word of that block to 0xFFFF.
- R6: An accepted erase or program holds `ready` low for exactly BUSY_CYC clocks and switches to the status view. Status bit 7 mirrors `ready`. Commands written while busy are ignored.
- R7: Raising `ce_n` during an operation (standby) does not lengthen, stop or alter it.
- R8: A program or erase aimed at a locked block is not carried out. It sets status bit 1, plus bit 4 for a program or bit 5 for an erase. Command 0x60 unlocks the addressed block, and command 0x50 clears the error bits.
- R9: While `dev_rst_n` is 0 the outputs are off. The array view is forced, the error bits are cleared (status reads 0x80 when ready) and all blocks are locked. Array contents are kept.
- R10: `dev_rst_n` going low during an operation aborts it and leaves the target word(s) unchanged. `ready` stays 0 through the reset and for RECOV_CYC+1 clocks after release.
- R11: After `dev_rst_n` rises, `dq_oe` stays 0 for WAKE_CYC clocks. A command write is ignored unless at least RECOV_CYC clocks have passed since release when its rising write edge is sampled.
- R12: If reset arrives on the same clock as the final countdown step, the abort wins. A reset one clock later finds the operation complete and leaves `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; commands taken on its rise |
| dev_rst_n | input | 1 | Device reset / deep power-down, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input (command in bits 7:0) |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 1 | Data bus tri-state enable |
| ready | output | 1 | Ready (1) / busy (0) |

## Verification
The two functions that can land on the same clock are completion of the busy countdown and the abort caused by the device reset. The bench lowers `dev_rst_n` in the half-cycle just before the final countdown edge, and again in a second run one clock later. It judges each outcome by reading back the target word and watching `ready`. The abort case must leave the word erased and keep `ready` low. The late case must store the programmed value and leave `ready` high. The same method is used at the recovery boundary, where a command edge is placed one clock before and exactly at the recovery threshold.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROGRAM    = 8'h40;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_UNLOCK     = 8'h60;

endpackage

// File: rtl/fbc_wake_timer.sv
module fbc_wake_timer #(
  parameter int WAKE_CYC  = 3,
  parameter int RECOV_CYC = 5
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic dev_rst_n,
  output logic out_ok,
  output logic cmd_ok
);

  localparam int CNT_W = $clog2(RECOV_CYC + 1);
  localparam logic [CNT_W-1:0] WAKE_V  = CNT_W'(WAKE_CYC);
  localparam logic [CNT_W-1:0] RECOV_V = CNT_W'(RECOV_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!dev_rst_n)            cnt_d = '0;
    else if (cnt_q != RECOV_V) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RECOV_V;
    else         cnt_q <= cnt_d;
  end

  assign out_ok = (cnt_q >= WAKE_V);
  assign cmd_ok = (cnt_q == RECOV_V);

  // R11
  sleep_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !dev_rst_n |=> (!out_ok && !cmd_ok));

endmodule

// File: rtl/fbc_op_engine.sv
module fbc_op_engine import fbc_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int BUSY_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              dev_rst_n,
  input  logic              cmd_ok,
  input  logic              start_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              commit_o,
  output op_kind_e          kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o
);

  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(BUSY_CYC - 1);

  logic              busy_q, busy_d;
  logic              hold_q, hold_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;
  logic              done;

  assign done = busy_q && (cnt_q == '0) && dev_rst_n;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (!dev_rst_n) begin
      busy_d = 1'b0;
      if (busy_q) hold_d = 1'b1;
    end else begin
      if (cmd_ok) hold_d = 1'b0;
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = LAST_V;
      end else if (done) begin
        busy_d = 1'b0;
      end else if (busy_q) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      kind_q <= kind_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign busy_o   = busy_q;
  assign ready_o  = !busy_q && !hold_q;
  assign commit_o = done;
  assign kind_o   = kind_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  // R10
  abort_stops_op_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !dev_rst_n) |=> (!busy_q && !ready_o));

  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && (cnt_q != '0) && dev_rst_n) |=> busy_q);

endmodule

// File: rtl/fbc_store.sv
module fbc_store import fbc_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int BLK_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   dev_rst_n,
  input  logic                   commit_i,
  input  op_kind_e               op_kind_i,
  input  logic [ADDR_W-1:0]      op_addr_i,
  input  logic [15:0]            op_data_i,
  input  logic                   unlock_i,
  input  logic [ADDR_W-1:0]      look_addr_i,
  output logic [15:0]            rd_data_o,
  output logic                   rd_locked_o,
  output logic [(1<<BLK_W)-1:0]  locks_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;

  logic [15:0]      mem_q  [DEPTH];
  logic [15:0]      wr_val [DEPTH];
  logic [DEPTH-1:0] wr_en;
  logic [BLK_W-1:0] op_blk, look_blk;

  assign op_blk   = op_addr_i[ADDR_W-1 -: BLK_W];
  assign look_blk = look_addr_i[ADDR_W-1 -: BLK_W];

  always_comb begin
    for (int w = 0; w < DEPTH; w++) begin
      if (op_kind_i == OP_ERASE) begin
        wr_en[w]  = commit_i && (op_blk == BLK_W'(w >> OFF_W));
        wr_val[w] = 16'hFFFF;
      end else begin
        wr_en[w]  = commit_i && (op_addr_i == ADDR_W'(w));
        wr_val[w] = mem_q[w] & op_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= 16'hFFFF;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (wr_en[w]) mem_q[w] <= wr_val[w];
      end
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_lock
    logic lock_q, lock_d;

    always_comb begin
      lock_d = lock_q;
      if (!dev_rst_n)                                     lock_d = 1'b1;
      else if (unlock_i && (look_blk == BLK_W'(b)))       lock_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) lock_q <= 1'b1;
      else         lock_q <= lock_d;
    end

    assign locks_o[b] = lock_q;
  end

  assign rd_data_o   = mem_q[look_addr_i];
  assign rd_locked_o = locks_o[look_blk];

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl import fbc_pkg::*; #(
  parameter int          ADDR_W    = 4,
  parameter int          BLK_W     = 2,
  parameter int          BUSY_CYC  = 6,
  parameter int          WAKE_CYC  = 3,
  parameter int          RECOV_CYC = 5,
  parameter logic [15:0] MFR_CODE  = 16'h00A5,
  parameter logic [15:0] DEV_CODE  = 16'h4C21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              dev_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              ready
);

  localparam int NBLK = 1 << BLK_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic              out_ok, cmd_ok;
  logic              busy, commit;
  logic              start, unlock;
  op_kind_e          start_kind, op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_data;
  logic [15:0]       arr_word;
  logic              addr_locked;
  logic [NBLK-1:0]   locks;

  fbc_wake_timer #(
    .WAKE_CYC (WAKE_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) wake_i (
    .clk      (clk),
    .rst_ni   (rst_i),
    .dev_rst_n(dev_rst_n),
    .out_ok   (out_ok),
    .cmd_ok   (cmd_ok)
  );

  fbc_op_engine #(
    .ADDR_W  (ADDR_W),
    .BUSY_CYC(BUSY_CYC)
  ) engine_i (
    .clk      (clk),
    .rst_ni   (rst_i),
    .dev_rst_n(dev_rst_n),
    .cmd_ok   (cmd_ok),
    .start_i  (start),
    .kind_i   (start_kind),
    .addr_i   (addr),
    .data_i   (dq_in),
    .busy_o   (busy),
    .ready_o  (ready),
    .commit_o (commit),
    .kind_o   (op_kind),
    .addr_o   (op_addr),
    .data_o   (op_data)
  );

  fbc_store #(
    .ADDR_W(ADDR_W),
    .BLK_W (BLK_W)
  ) store_i (
    .clk        (clk),
    .rst_ni     (rst_i),
    .dev_rst_n  (dev_rst_n),
    .commit_i   (commit),
    .op_kind_i  (op_kind),
    .op_addr_i  (op_addr),
    .op_data_i  (op_data),
    .unlock_i   (unlock),
    .look_addr_i(addr),
    .rd_data_o  (arr_word),
    .rd_locked_o(addr_locked),
    .locks_o    (locks)
  );

  // command interface state
  rd_mode_e mode_q, mode_d;
  logic     wait_q, wait_d;
  logic     lerr_q, lerr_d, perr_q, perr_d, eerr_q, eerr_d;
  logic     we_q;
  logic     accept;

  assign accept = dev_rst_n && cmd_ok && !busy && !ce_n && we_n && !we_q;

  always_comb begin
    mode_d     = mode_q;
    wait_d     = wait_q;
    lerr_d     = lerr_q;
    perr_d     = perr_q;
    eerr_d     = eerr_q;
    start      = 1'b0;
    start_kind = OP_PROG;
    unlock     = 1'b0;
    if (!dev_rst_n) begin
      mode_d = RD_ARRAY;
      wait_d = 1'b0;
      lerr_d = 1'b0;
      perr_d = 1'b0;
      eerr_d = 1'b0;
    end else if (accept) begin
      if (wait_q) begin
        wait_d = 1'b0;
        mode_d = RD_STATUS;
        if (addr_locked) begin
          lerr_d = 1'b1;
          perr_d = 1'b1;
        end else begin
          start = 1'b1;
        end
      end else begin
        case (dq_in[7:0])
          CMD_RD_ARRAY:  mode_d = RD_ARRAY;
          CMD_RD_IDENT:  mode_d = RD_IDENT;
          CMD_RD_STATUS: mode_d = RD_STATUS;
          CMD_CLR_STATUS: begin
            lerr_d = 1'b0;
            perr_d = 1'b0;
            eerr_d = 1'b0;
          end
          CMD_PROGRAM: begin
            wait_d = 1'b1;
            mode_d = RD_STATUS;
          end
          CMD_ERASE: begin
            mode_d = RD_STATUS;
            if (addr_locked) begin
              lerr_d = 1'b1;
              eerr_d = 1'b1;
            end else begin
              start      = 1'b1;
              start_kind = OP_ERASE;
            end
          end
          CMD_UNLOCK: unlock = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q <= RD_ARRAY;
      wait_q <= 1'b0;
      lerr_q <= 1'b0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      we_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      wait_q <= wait_d;
      lerr_q <= lerr_d;
      perr_q <= perr_d;
      eerr_q <= eerr_d;
      we_q   <= we_n;
    end
  end

  // read path
  logic [15:0] rd_val;
  logic [7:0]  status;

  assign status = {ready, 1'b0, eerr_q, perr_q, 2'b00, lerr_q, 1'b0};

  always_comb begin
    case (mode_q)
      RD_ARRAY: rd_val = arr_word;
      RD_IDENT: begin
        case (addr[1:0])
          2'd0:    rd_val = MFR_CODE;
          2'd1:    rd_val = DEV_CODE;
          2'd2:    rd_val = {15'd0, addr_locked};
          default: rd_val = 16'd0;
        endcase
      end
      RD_STATUS: rd_val = {8'd0, status};
      default:   rd_val = 16'd0;
    endcase
  end

  assign dq_oe  = !ce_n && !oe_n && we_n && dev_rst_n && out_ok;
  assign dq_out = dq_oe ? rd_val : 16'd0;

  // R9
  sleep_restores_view_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !dev_rst_n |=> ((mode_q == RD_ARRAY) && (&locks)));

  // R6
  status_ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (dq_oe && (mode_q == RD_STATUS)) |-> (dq_out[7] == ready));

endmodule

// File: tb/flash_bus_ctrl_tb_top.sv
module flash_bus_ctrl_tb_top;

  localparam int ADDR_W = 4;
  localparam int BLK_W  = 2;
  localparam int BUSY   = 6;
  localparam int WAKE   = 3;
  localparam int RECOV  = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h4C21;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, ce_n, oe_n, we_n, dev_rst_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       dq_in, dq_out;
  logic              dq_oe, ready;

  flash_bus_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYC(BUSY), .WAKE_CYC(WAKE),
    .RECOV_CYC(RECOV), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dev_rst_n(dev_rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ready(ready)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_mem [DEPTH];

  function automatic logic [15:0] pat(input int a);
    return 16'h5A0F ^ (16'(a) * 16'h1111);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr_cmd(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dq_out;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic program_word(input int a, input logic [15:0] d, output int n);
    wr_cmd(a, 16'h0040);
    wr_cmd(a, d);
    wait_ready(n);
  endtask

  task automatic sleep_pulse();
    @(negedge clk);
    dev_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (RECOV + 3) @(negedge clk);
  endtask

  task automatic check_array(input string req);
    logic [15:0] v;
    wr_cmd(0, 16'h00FF);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(req, v, exp_mem[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    rst_n = 1'b0; dev_rst_n = 1'b1; addr = '0; dq_in = '0;
    idle();
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: reset state
    chk("R3 ready", ready, 1);
    chk("R3 dq_oe", dq_oe, 0);

    // R1: sweep every pin combination
    for (int c = 0; c < 16; c++) begin
      logic e;
      @(negedge clk);
      {ce_n, oe_n, we_n, dev_rst_n} = c[3:0];
      dq_in = 16'h0000;
      addr = '0;
      e = (c[3:0] == 4'b0011);
      #1;
      chk("R1 dq_oe", dq_oe, e);
      chk("R1 dq_out", dq_out, e ? 16'hFFFF : 16'h0000);
      @(negedge clk);
      idle(); dev_rst_n = 1'b1;
      if (!c[0]) repeat (RECOV + 3) @(negedge clk);
    end

    // R3: erased contents after reset
    check_array("R3 erased");

    // R2: identifier view, R3 all locked
    wr_cmd(0, 16'h0090);
    rd(0, v); chk("R2 mfr", v, MFR);
    rd(1, v); chk("R2 dev", v, DEV);
    rd(3, v); chk("R2 id3", v, 0);
    for (int b = 0; b < 4; b++) begin
      rd(b * 4 + 2, v); chk("R3 lock", v, 1);
    end

    // R8: locked block rejects program and erase
    program_word(5, 16'h1234, n);
    chk("R8 no busy", n, 0);
    rd(0, v); chk("R8 prog status", v, 16'h0092);
    wr_cmd(0, 16'h0050);
    rd(0, v); chk("R8 clear", v, 16'h0080);
    wr_cmd(9, 16'h0020);
    rd(0, v); chk("R8 erase status", v, 16'h00A2);
    wr_cmd(0, 16'h0050);
    check_array("R8 untouched");

    // R8: unlock all blocks
    for (int b = 0; b < 4; b++) wr_cmd(b * 4, 16'h0060);
    wr_cmd(0, 16'h0090);
    for (int b = 0; b < 4; b++) begin
      rd(b * 4 + 2, v); chk("R8 unlocked", v, 0);
    end

    // R4, R6, R7: program every word (ce_n high while busy)
    for (int a = 0; a < DEPTH; a++) begin
      program_word(a, pat(a), n);
      chk("R6 R7 busy length", n, BUSY);
      exp_mem[a] = exp_mem[a] & pat(a);
    end
    rd(0, v); chk("R6 status view", v, 16'h0080);
    check_array("R4 program");

    // R4: program clears bits only
    program_word(3, 16'h0FF0, n);
    exp_mem[3] = exp_mem[3] & 16'h0FF0;
    check_array("R4 and");

    // R5: block erase
    wr_cmd(9, 16'h0020);
    wait_ready(n);
    chk("R5 busy length", n, BUSY);
    for (int a = 8; a < 12; a++) exp_mem[a] = 16'hFFFF;
    check_array("R5 erase");

    // R6: status while busy, commands ignored while busy
    wr_cmd(8, 16'h0040);
    wr_cmd(8, 16'hC3C3);
    rd(0, v); chk("R6 busy status", v, 16'h0000);
    wr_cmd(0, 16'h00FF);
    wait_ready(n);
    rd(0, v); chk("R6 ignored cmd", v, 16'h0080);
    exp_mem[8] = 16'hC3C3;
    check_array("R6 result");

    // R10: abort during program
    wr_cmd(9, 16'h0040);
    wr_cmd(9, 16'h1111);
    repeat (2) @(negedge clk);
    dev_rst_n = 1'b0;
    @(negedge clk);
    #1 chk("R10 ready low", ready, 0);
    @(negedge clk);
    dev_rst_n = 1'b1;
    #1 n = 0;
    while (!ready && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R10 ready hold", n, RECOV + 1);
    repeat (3) @(negedge clk);
    rd(9, v); chk("R9 array view", v, 16'hFFFF);
    wr_cmd(0, 16'h0090);
    for (int b = 0; b < 4; b++) begin
      rd(b * 4 + 2, v); chk("R9 relocked", v, 1);
    end
    wr_cmd(0, 16'h0070);
    rd(0, v); chk("R9 status", v, 16'h0080);
    check_array("R10 untouched");

    // R9: error bits cleared by reset
    program_word(1, 16'h0000, n);
    rd(0, v); chk("R9 err set", v, 16'h0092);
    sleep_pulse();
    wr_cmd(0, 16'h0070);
    rd(0, v); chk("R9 err cleared", v, 16'h0080);

    // R11: wake-up delay on outputs
    @(negedge clk);
    dev_rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = '0;
    repeat (2) @(negedge clk);
    #1 chk("R9 off in sleep", dq_oe, 0);
    @(negedge clk);
    dev_rst_n = 1'b1;
    #1 n = 0;
    while (!dq_oe && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R11 wake", n, WAKE);
    chk("R11 data", dq_out, exp_mem[0]);
    @(negedge clk);
    idle();

    // R11: recovery boundary, one clock early then exactly on time
    for (int j = RECOV - 3; j <= RECOV - 2; j++) begin
      @(negedge clk);
      dev_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      dev_rst_n = 1'b1;
      repeat (j) @(negedge clk);
      wr_cmd(0, 16'h0070);
      repeat (RECOV + 2) @(negedge clk);
      rd(0, v);
      chk("R11 recovery", v, (j >= RECOV - 2) ? 16'h0080 : exp_mem[0]);
    end

    // R12: reset lands on the final countdown edge
    wr_cmd(8, 16'h0060);
    wr_cmd(10, 16'h0040);
    wr_cmd(10, 16'h00F0);
    repeat (BUSY - 1) @(negedge clk);
    dev_rst_n = 1'b0;
    @(negedge clk);
    #1 chk("R12 abort ready", ready, 0);
    @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (RECOV + 3) @(negedge clk);
    rd(10, v); chk("R12 abort data", v, 16'hFFFF);

    // R12: reset one clock later finds the program complete
    wr_cmd(8, 16'h0060);
    wr_cmd(10, 16'h0040);
    wr_cmd(10, 16'h0F00);
    repeat (BUSY) @(negedge clk);
    dev_rst_n = 1'b0;
    #1 chk("R12 late ready", ready, 1);
    @(negedge clk);
    #1 chk("R12 late ready held", ready, 1);
    @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (RECOV + 3) @(negedge clk);
    exp_mem[10] = 16'h0F00;
    rd(10, v); chk("R12 late data", v, 16'h0F00);
    check_array("R12 array");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule